// File: doc/BRIEF.md
# Privilege-Aware Virtual Address Segment Decoder

This block sorts each 32-bit virtual address into one of three outcomes before any translation lookaside buffer is consulted. From the two-bit privilege field and the exception-level and error-level status bits it works out the effective privilege. It then checks the top address bits against the windows that privilege may reach.

Two windows in kernel space are direct-mapped. For these the block produces the physical address at once, by clearing the top three address bits, and marks the access cacheable or uncached. An address that the current privilege may not touch raises an address fault. The fault carries a tag that says whether the access was a load or a store. Every other address is flagged for mapped translation further down the pipe.

The decoder is purely combinational, so its outputs follow its inputs in the same cycle. The three privilege levels and the four classification outcomes are held as enumerations, and the top module selects among them with unique case.

Top module: `addr_seg_decoder`

## Requirements
- R1: When `exl` or `erl` is 1, the address is decoded as kernel, whatever `priv_mode` holds.
- R2: `priv_mode` encodes 0 as kernel, 1 as supervisor and 2 as user; the value 3 is decoded as kernel.
- R3: In kernel, an address in 0x80000000–0x9FFFFFFF gives `direct`=1 and `uncached`=0, with `paddr` = vaddr − 0x80000000.
- R4: In kernel, an address in 0xA0000000–0xBFFFFFFF gives `direct`=1 and `uncached`=1, with `paddr` = vaddr − 0xA0000000.
- R5: In kernel, any address whose bits [31:30] are not 2'b10 gives `mapped`=1.
- R6: In supervisor, an address whose bits [31:29] are 3'b000 or 3'b110 gives `mapped`=1; any other value gives `addr_err`=1.
- R7: In user, an address with bit 31 set gives `addr_err`=1; otherwise `mapped`=1.
- R8: `err_store` equals `is_store` whenever `addr_err` is 1, and is 0 otherwise.
- R9: With `req_valid`=1 exactly one of `direct`, `mapped`, `addr_err` is 1. With `req_valid`=0 all outputs are 0. `paddr` and `uncached` are 0 unless `direct` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| req_valid | input | 1 | A request is present this cycle |
| vaddr | input | 32 | Virtual address to classify |
| priv_mode | input | 2 | Privilege field: 0 kernel, 1 supervisor, 2 user, 3 reserved |
| exl | input | 1 | Exception-level status bit |
| erl | input | 1 | Error-level status bit |
| is_store | input | 1 | 1 for a store, 0 for a load |
| paddr | output | 32 | Physical address for direct-mapped windows |
| direct | output | 1 | Address is translated without lookup |
| uncached | output | 1 | Direct window bypasses the cache |
| mapped | output | 1 | Address needs mapped translation |
| addr_err | output | 1 | Address fault for this privilege |
| err_store | output | 1 | Fault was raised by a store |

## Verification
The block is combinational, so a wrong privilege or window decision shows on the outputs in the same cycle as the input that caused it. An error in privilege resolution shows up as a fault or mapped flag where a direct hit was expected, or the reverse. The windows are selected by the top address bits only. Sweeping every top nibble against several offset patterns, under every combination of privilege field, status bits and access type, therefore exposes any wrong boundary or wrong offset bit on the first vector that touches it.

// File: rtl/addr_seg_pkg.sv
package addr_seg_pkg;
    typedef enum logic [1:0] {
        PRIV_KERNEL = 2'd0,
        PRIV_SUPER  = 2'd1,
        PRIV_USER   = 2'd2
    } priv_e;

    typedef enum logic [1:0] {
        CLS_MAPPED          = 2'd0,
        CLS_DIRECT_CACHED   = 2'd1,
        CLS_DIRECT_UNCACHED = 2'd2,
        CLS_FAULT           = 2'd3
    } seg_cls_e;

    localparam int SEG_TOP_BITS = 3;
endpackage

// File: rtl/seg_priv_resolve.sv
module seg_priv_resolve
    import addr_seg_pkg::*;
(
    input  logic [1:0] mode_field,
    input  logic       exl,
    input  logic       erl,
    output priv_e      priv
);
    always_comb begin
        if (exl || erl) begin
            priv = PRIV_KERNEL;
        end else begin
            unique case (mode_field)
                2'd1:    priv = PRIV_SUPER;
                2'd2:    priv = PRIV_USER;
                default: priv = PRIV_KERNEL;
            endcase
        end
    end
endmodule

// File: rtl/seg_window_decode.sv
module seg_window_decode
    import addr_seg_pkg::*;
(
    input  logic [SEG_TOP_BITS-1:0] top_bits,
    input  priv_e                   priv,
    output seg_cls_e                cls
);
    always_comb begin
        cls = CLS_MAPPED;
        unique case (priv)
            PRIV_KERNEL: begin
                if (top_bits == 3'b100)      cls = CLS_DIRECT_CACHED;
                else if (top_bits == 3'b101) cls = CLS_DIRECT_UNCACHED;
                else                         cls = CLS_MAPPED;
            end
            PRIV_SUPER: begin
                if (top_bits == 3'b000 || top_bits == 3'b110) cls = CLS_MAPPED;
                else                                          cls = CLS_FAULT;
            end
            PRIV_USER: begin
                if (top_bits[SEG_TOP_BITS-1]) cls = CLS_FAULT;
                else                          cls = CLS_MAPPED;
            end
            default: cls = CLS_MAPPED;
        endcase
    end
endmodule

// File: rtl/seg_direct_map.sv
module seg_direct_map
    import addr_seg_pkg::*;
#(
    parameter int ADDR_W = 32,
    localparam int OFF_W = ADDR_W - SEG_TOP_BITS
) (
    input  logic [OFF_W-1:0]  offset,
    input  logic              enable,
    output logic [ADDR_W-1:0] paddr
);
    always_comb begin
        paddr = enable ? {{SEG_TOP_BITS{1'b0}}, offset} : '0;
    end
endmodule

// File: rtl/addr_seg_decoder.sv
module addr_seg_decoder
    import addr_seg_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] vaddr,
    input  logic [1:0]        priv_mode,
    input  logic              exl,
    input  logic              erl,
    input  logic              is_store,
    output logic [ADDR_W-1:0] paddr,
    output logic              direct,
    output logic              uncached,
    output logic              mapped,
    output logic              addr_err,
    output logic              err_store
);
    localparam int OFF_W = ADDR_W - SEG_TOP_BITS;

    priv_e    priv;
    seg_cls_e cls;

    seg_priv_resolve u_priv (
        .mode_field (priv_mode),
        .exl        (exl),
        .erl        (erl),
        .priv       (priv)
    );

    seg_window_decode u_window (
        .top_bits (vaddr[ADDR_W-1 -: SEG_TOP_BITS]),
        .priv     (priv),
        .cls      (cls)
    );

    seg_direct_map #(.ADDR_W(ADDR_W)) u_dmap (
        .offset (vaddr[OFF_W-1:0]),
        .enable (direct),
        .paddr  (paddr)
    );

    always_comb begin
        direct    = 1'b0;
        uncached  = 1'b0;
        mapped    = 1'b0;
        addr_err  = 1'b0;
        if (req_valid) begin
            unique case (cls)
                CLS_DIRECT_CACHED:   direct = 1'b1;
                CLS_DIRECT_UNCACHED: begin
                    direct   = 1'b1;
                    uncached = 1'b1;
                end
                CLS_FAULT:           addr_err = 1'b1;
                default:             mapped = 1'b1;
            endcase
        end
        err_store = addr_err & is_store;
    end

    always_comb begin
        // R9
        one_class_chk: assert ($countones({direct, mapped, addr_err}) == (req_valid ? 1 : 0))
            else $error("outcome flags not exclusive");
        // R8
        err_tag_chk: assert (addr_err || !err_store)
            else $error("store tag without fault");
        // R9
        uncached_scope_chk: assert (direct || (!uncached && paddr == '0))
            else $error("direct-only outputs active");
        // R3
        paddr_range_chk: assert (!direct || paddr[ADDR_W-1 -: SEG_TOP_BITS] == '0)
            else $error("direct address outside window");
        // R7
        user_fault_chk: assert (!(req_valid && priv_mode == 2'd2 && !exl && !erl && vaddr[ADDR_W-1]) || addr_err)
            else $error("user access to upper half not faulted");
        // R1
        status_kernel_chk: assert (!(req_valid && (exl || erl) && vaddr[ADDR_W-1 -: 2] == 2'b10) || direct)
            else $error("status override did not select kernel");
    end
endmodule

// File: tb/addr_seg_decoder_bench.sv
module addr_seg_decoder_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [31:0] vaddr = '0;
    logic [1:0]  priv_mode = '0;
    logic        exl = 1'b0, erl = 1'b0, is_store = 1'b0;
    logic [31:0] paddr;
    logic        direct, uncached, mapped, addr_err, err_store;
    int          checks = 0;
    int          errors = 0;
    logic        done = 1'b0;

    always #10 clk = ~clk;

    addr_seg_decoder u_addr_seg_decoder (
        .req_valid (req_valid), .vaddr (vaddr), .priv_mode (priv_mode),
        .exl (exl), .erl (erl), .is_store (is_store),
        .paddr (paddr), .direct (direct), .uncached (uncached),
        .mapped (mapped), .addr_err (addr_err), .err_store (err_store)
    );

    task automatic check(input string tag, input logic [35:0] act, input logic [35:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: vaddr=%h mode=%0d exl=%0b erl=%0b st=%0b actual=%h expected=%h",
                     tag, vaddr, priv_mode, exl, erl, is_store, act, exp);
        end
    endtask

    task automatic apply_and_check(input logic v, input logic [31:0] va, input logic [1:0] md,
                                   input logic e1, input logic e2, input logic st);
        logic kern, sup, e_dir, e_unc, e_map, e_err;
        logic [31:0] e_pa;
        string tag;
        @(negedge clk);
        req_valid = v; vaddr = va; priv_mode = md; exl = e1; erl = e2; is_store = st;
        #5;
        kern = e1 | e2 | (md == 2'd0) | (md == 2'd3);
        sup  = !kern && md == 2'd1;
        e_dir = 0; e_unc = 0; e_map = 0; e_err = 0; e_pa = 32'h0;
        if (!v) begin
            tag = "R9";
        end else if (kern) begin
            if (va >= 32'h8000_0000 && va < 32'hC000_0000) begin
                e_dir = 1;
                e_unc = (va >= 32'hA000_0000);
                e_pa  = e_unc ? va - 32'hA000_0000 : va - 32'h8000_0000;
            end else begin
                e_map = 1;
            end
            if ((e1 | e2) && (md == 2'd1 || md == 2'd2)) tag = "R1";
            else if (md == 2'd3)                         tag = "R2";
            else if (e_dir)                              tag = e_unc ? "R4" : "R3";
            else                                         tag = "R5";
        end else if (sup) begin
            if (va < 32'h2000_0000 || (va >= 32'hC000_0000 && va < 32'hE000_0000)) e_map = 1;
            else e_err = 1;
            tag = "R6";
        end else begin
            if (va >= 32'h8000_0000) e_err = 1;
            else e_map = 1;
            tag = "R7";
        end
        check(tag, {direct, uncached, mapped, addr_err, paddr},
                   {e_dir, e_unc, e_map, e_err, e_pa});
        check("R8", {35'h0, err_store}, {35'h0, e_err & st});
    endtask

    localparam logic [27:0] LOW_PAT [3] = '{28'h0000000, 28'hABCDEF5, 28'hFFFFFFF};

    initial begin
        // reset state: idle request gives quiet outputs (R9)
        repeat (3) @(negedge clk);
        #5;
        check("R9", {direct, uncached, mapped, addr_err, err_store, paddr},
                    {5'b0, 32'h0});
        rst_n = 1'b1;
        for (int n = 0; n < 16; n++)
            for (int p = 0; p < 3; p++)
                for (int m = 0; m < 4; m++)
                    for (int s = 0; s < 8; s++)
                        apply_and_check(1'b1, {n[3:0], LOW_PAT[p]}, m[1:0], s[0], s[1], s[2]);
        for (int n = 0; n < 16; n++)
            apply_and_check(1'b0, {n[3:0], 28'h1234567}, 2'd0, 1'b0, 1'b0, 1'b1);
        // exact window edges (R3, R4, R5)
        apply_and_check(1'b1, 32'h7FFF_FFFF, 2'd0, 1'b0, 1'b0, 1'b0);
        apply_and_check(1'b1, 32'h9FFF_FFFF, 2'd0, 1'b0, 1'b0, 1'b0);
        apply_and_check(1'b1, 32'hA000_0000, 2'd0, 1'b0, 1'b0, 1'b0);
        apply_and_check(1'b1, 32'hBFFF_FFFF, 2'd0, 1'b0, 1'b0, 1'b1);
        apply_and_check(1'b1, 32'hC000_0000, 2'd0, 1'b0, 1'b0, 1'b0);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule